// File: doc/BRIEF.md
# Serial interrupt host controller

This block is the host end of a single-wire, open-drain interrupt serialiser that runs on the PCI clock. The line is shared and pulled high. A low is driven on it only through an output enable. The host opens each round with a Start Frame. It then reads one slot per data frame at fixed clock offsets. It closes the round with a Stop Frame, and the length of that Stop Frame tells every device which mode the next round uses. In continuous mode the host opens every round itself. In quiet mode the host stays silent until some device pulls the line low, and then it drives the rest of the Start Frame.

The slots sampled in a round are stored as active-low levels. Each level is held until the same slot is sampled in a later round. Frames 0 to 15 carry IRQ0 to IRQ15, except that frame 2 carries a system-management request. The IRQ0, IRQ8 and IRQ13 slots are discarded because those sources exist only inside the chip. IRQ14 and IRQ15 are plain interrupt lines like the others. Frames 17 to 20 carry PCI INTA to INTD. Each of these is merged with the matching PCI pin, so either the pin or the slot can pull the output low. Frame 16 is sampled but not used.

Top module: `sirq_host`

## Requirements
- R1: Out of reset the mode is continuous. In continuous mode, the host enables the line driver in the clock after the idle clock and keeps it enabled for 4 clocks to form the Start Frame.
- R2: In quiet mode, the host does not enable its driver while the line stays high in idle. When the line is sampled low in idle, the host enables its driver for the next 3 clocks, so the Start Frame is 4 clocks long in total.
- R3: After the turnaround clock of the last frame, the host enables its driver for the Stop Frame. The Stop Frame is 2 clocks long when `short_stop` is 1 and 3 clocks long when it is 0. `short_stop` is read as the Stop Frame begins. A 2-clock Stop Frame makes the next round quiet, and a 3-clock Stop Frame makes it continuous.
- R4: Counting the first clock after the Start Frame as clock 0, frame k is sampled on clock 2+3k. The host never drives the line in a sample clock. There are 21 frames per round.
- R5: `irq_n[k]` for k in {1,3,4,5,6,7,9,10,11,12,14,15} equals the line level sampled in frame k. It is held until frame k is sampled again.
- R6: `irq_n[0]`, `irq_n[2]`, `irq_n[8]` and `irq_n[13]` stay 1 whatever the line does in those frames.
- R7: `smi_req` is 1 while the latest sample of frame 2 was low. `smi_sts` is set whenever frame 2 is sampled low and stays set until a cycle with `smi_sts_clr` at 1. A new set wins over a clear in the same cycle.
- R8: `pci_int_out_n[i]` is the AND of the level last sampled in frame 17+i and `pci_int_in_n[i]`, for i = 0..3 (A..D).
- R9: While reset is asserted, the driver is off, `irq_n` is 16'hFFFF, `smi_req` and `smi_sts` are 0, and `pci_int_out_n` equals `pci_int_in_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_line_in | input | 1 | Level of the shared serial interrupt line |
| ser_line_oe | output | 1 | Pulls the line low while 1 |
| short_stop | input | 1 | 1 selects a 2-clock Stop Frame (quiet), 0 a 3-clock one (continuous) |
| smi_sts_clr | input | 1 | Clears the sticky SMI status |
| pci_int_in_n | input | 4 | PCI INTA..INTD pins, active low |
| irq_n | output | 16 | Decoded interrupt levels, active low |
| smi_req | output | 1 | System-management request, active high |
| smi_sts | output | 1 | Sticky SMI status |
| pci_int_out_n | output | 4 | Merged PCI interrupts A..D, active low |

## Verification
A slot result is due at the rising edge that closes its sample clock, which is clock 2+3k after the Start Frame. The bench finds the end of the Start Frame by watching the driver enable. It then counts falling edges so that it drives each device low for exactly one sample clock. The decoded outputs are checked only after the Stop Frame, once every frame of the round has been sampled. The Start Frame and Stop Frame lengths are measured as runs of falling edges with the driver enabled. The PCI merge is combinational and is checked in the same cycle as the round results.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_GAP,
    ST_DATA,
    ST_STOP,
    ST_SREC,
    ST_STA
  } sirq_state_e;
endpackage

// File: rtl/sirq_rst_sync.sv
module sirq_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) sync_q <= 2'b00;
    else              sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/sirq_seq.sv
module sirq_seq
  import sirq_pkg::*;
#(
  parameter int NUM_FRAMES = 21,
  parameter int START_CLKS = 4,
  localparam int FW = $clog2(NUM_FRAMES),
  localparam int CW = (START_CLKS > 3) ? $clog2(START_CLKS) : 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_in,
  input  logic          short_stop,
  output logic          line_oe,
  output logic          sample_en,
  output logic [FW-1:0] frame_idx
);
  localparam logic [CW-1:0] START_LAST = CW'(START_CLKS - 1);
  localparam logic [FW-1:0] FRAME_LAST = FW'(NUM_FRAMES - 1);

  sirq_state_e   state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [1:0]    phase_q, phase_d;
  logic [FW-1:0] frame_q, frame_d;
  logic          quiet_q, quiet_d;
  logic          stop2_q, stop2_d;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    phase_d = phase_q;
    frame_d = frame_q;
    quiet_d = quiet_q;
    stop2_d = stop2_q;
    unique case (state_q)
      ST_IDLE: begin
        if (!quiet_q) begin
          state_d = ST_START;
          cnt_d   = '0;
        end else if (!line_in) begin
          // a device drove the first start clock; the host supplies the rest
          state_d = ST_START;
          cnt_d   = CW'(1);
        end
      end
      ST_START: begin
        if (cnt_q == START_LAST) begin
          state_d = ST_GAP;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_GAP: begin
        if (cnt_q == CW'(1)) begin
          state_d = ST_DATA;
          phase_d = 2'd0;
          frame_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_DATA: begin
        if (phase_q == 2'd2) begin
          phase_d = 2'd0;
          if (frame_q == FRAME_LAST) begin
            state_d = ST_STOP;
            cnt_d   = '0;
            stop2_d = short_stop;
          end else begin
            frame_d = frame_q + 1'b1;
          end
        end else begin
          phase_d = phase_q + 1'b1;
        end
      end
      ST_STOP: begin
        if ((stop2_q && cnt_q == CW'(1)) || cnt_q == CW'(2)) begin
          state_d = ST_SREC;
          quiet_d = stop2_q;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SREC: state_d = ST_STA;
      ST_STA:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      phase_q <= 2'd0;
      frame_q <= '0;
      quiet_q <= 1'b0;
      stop2_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
      frame_q <= frame_d;
      quiet_q <= quiet_d;
      stop2_q <= stop2_d;
    end
  end

  assign line_oe   = (state_q == ST_START) || (state_q == ST_STOP);
  assign sample_en = (state_q == ST_DATA) && (phase_q == 2'd0);
  assign frame_idx = frame_q;

  // R1: continuous idle leads straight into a driven start clock
  a_r1_cont_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !quiet_q) |=> line_oe);

  // R2: quiet idle with a high line keeps the driver off
  a_r2_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && quiet_q && line_in) |=> !line_oe);

  // R4: the host never drives during a sample clock
  a_r4_release_sample: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en |-> !line_oe);
endmodule

// File: rtl/sirq_decode.sv
module sirq_decode #(
  parameter int NUM_FRAMES = 21,
  parameter int SMI_SLOT   = 2,
  parameter int PCI_BASE   = 17,
  parameter int PCI_CNT    = 4,
  localparam int FW = $clog2(NUM_FRAMES),
  localparam logic [15:0] DROP_MASK = 16'h2105 | (16'h1 << SMI_SLOT)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sample_en,
  input  logic [FW-1:0]      frame_idx,
  input  logic               line_in,
  input  logic               smi_sts_clr,
  input  logic [PCI_CNT-1:0] pci_int_in_n,
  output logic [15:0]        irq_n,
  output logic               smi_req,
  output logic               smi_sts,
  output logic [PCI_CNT-1:0] pci_int_out_n
);
  logic [NUM_FRAMES-1:0] slot_q, slot_d;
  logic                  sts_q, sts_d;
  logic                  smi_hit;

  // Per-slot write: only the frame being sampled takes the line level
  for (genvar k = 0; k < NUM_FRAMES; k++) begin : g_slot
    assign slot_d[k] = (sample_en && frame_idx == FW'(k)) ? line_in : slot_q[k];
  end

  assign smi_hit = sample_en && (frame_idx == FW'(SMI_SLOT)) && !line_in;

  always_comb begin
    sts_d = smi_hit | (sts_q & ~smi_sts_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '1;
      sts_q  <= 1'b0;
    end else begin
      slot_q <= slot_d;
      sts_q  <= sts_d;
    end
  end

  assign irq_n         = slot_q[15:0] | DROP_MASK;
  assign smi_req       = ~slot_q[SMI_SLOT];
  assign smi_sts       = sts_q;
  assign pci_int_out_n = slot_q[PCI_BASE +: PCI_CNT] & pci_int_in_n;

  // R5: levels only move on a sample clock
  a_r5_hold_levels: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en |=> $stable(irq_n));

  // R7: a fresh request always leaves the sticky status set
  a_r7_sts_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smi_req) |-> smi_sts);

  // R8: a low pin always reaches the merged output
  a_r8_pin_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((~pci_int_in_n) & pci_int_out_n) == '0);
endmodule

// File: rtl/sirq_host.sv
module sirq_host #(
  parameter int NUM_FRAMES = 21,
  parameter int START_CLKS = 4,
  parameter int PCI_BASE   = 17,
  localparam int FW = $clog2(NUM_FRAMES)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_line_in,
  output logic       ser_line_oe,
  input  logic       short_stop,
  input  logic       smi_sts_clr,
  input  logic [3:0] pci_int_in_n,
  output logic [15:0] irq_n,
  output logic       smi_req,
  output logic       smi_sts,
  output logic [3:0] pci_int_out_n
);
  logic          rst_n_s;
  logic          sample_en;
  logic [FW-1:0] frame_idx;

  sirq_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_s)
  );

  sirq_seq #(
    .NUM_FRAMES (NUM_FRAMES),
    .START_CLKS (START_CLKS)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .line_in    (ser_line_in),
    .short_stop (short_stop),
    .line_oe    (ser_line_oe),
    .sample_en  (sample_en),
    .frame_idx  (frame_idx)
  );

  sirq_decode #(
    .NUM_FRAMES (NUM_FRAMES),
    .SMI_SLOT   (2),
    .PCI_BASE   (PCI_BASE),
    .PCI_CNT    (4)
  ) u_dec (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .sample_en     (sample_en),
    .frame_idx     (frame_idx),
    .line_in       (ser_line_in),
    .smi_sts_clr   (smi_sts_clr),
    .pci_int_in_n  (pci_int_in_n),
    .irq_n         (irq_n),
    .smi_req       (smi_req),
    .smi_sts       (smi_sts),
    .pci_int_out_n (pci_int_out_n)
  );
endmodule

// File: tb/tb_sirq_host.sv
`timescale 1ns/1ps
module tb_sirq_host;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        dev_low;
  logic        ser_line;
  logic        ser_line_oe;
  logic        short_stop;
  logic        smi_sts_clr;
  logic [3:0]  pci_int_in_n;
  logic [15:0] irq_n;
  logic        smi_req;
  logic        smi_sts;
  logic [3:0]  pci_int_out_n;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #4 clk = ~clk;

  assign ser_line = ~(ser_line_oe | dev_low);

  sirq_host dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .ser_line_in   (ser_line),
    .ser_line_oe   (ser_line_oe),
    .short_stop    (short_stop),
    .smi_sts_clr   (smi_sts_clr),
    .pci_int_in_n  (pci_int_in_n),
    .irq_n         (irq_n),
    .smi_req       (smi_req),
    .smi_sts       (smi_sts),
    .pci_int_out_n (pci_int_out_n)
  );

  typedef struct packed {
    logic [20:0] pull;   // 1 = device pulls frame k low
    logic [3:0]  pin;
    logic [15:0] irq;
    logic        smi;
    logic        sts;
    logic [3:0]  pci;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{21'h000000, 4'hF, 16'hFFFF, 1'b0, 1'b0, 4'hF},
    '{21'h1FFFFF, 4'hF, 16'h2105, 1'b1, 1'b1, 4'h0},
    '{21'h00C00A, 4'hA, 16'h3FF5, 1'b0, 1'b1, 4'hA},
    '{21'h122101, 4'hD, 16'hFFFF, 1'b0, 1'b1, 4'h4},
    '{21'h0000F4, 4'hF, 16'hFF0F, 1'b1, 1'b1, 4'hF}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // One round: optional device start, then frames, then measure the stop frame.
  // Returns at the falling edge of the first clock after the stop frame.
  task automatic run_cycle(input logic [20:0] pull, input logic dev_start,
                           output int start_len, output int stop_len);
    if (dev_start) begin
      dev_low = 1'b1;
      @(negedge clk);
      dev_low = 1'b0;
    end
    while (!ser_line_oe) @(negedge clk);
    start_len = 0;
    while (ser_line_oe) begin
      start_len++;
      @(negedge clk);
    end
    @(negedge clk);
    @(negedge clk);
    for (int k = 0; k < 21; k++) begin
      dev_low = pull[k];
      @(negedge clk);
      dev_low = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
    stop_len = 0;
    while (ser_line_oe) begin
      stop_len++;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual %0d expected <= 20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    int sl, st, loud;
    dev_low      = 1'b0;
    short_stop   = 1'b0;
    smi_sts_clr  = 1'b0;
    pci_int_in_n = 4'b0110;
    rst_n        = 1'b0;
    @(negedge clk);
    @(negedge clk);
    // R9: reset state
    chk("R9 oe", {31'd0, ser_line_oe}, 32'd0);
    chk("R9 irq_n", {16'd0, irq_n}, 32'h0000FFFF);
    chk("R9 smi", {30'd0, smi_req, smi_sts}, 32'd0);
    chk("R9/R8 pci", {28'd0, pci_int_out_n}, 32'h6);
    pci_int_in_n = 4'hF;
    rst_n = 1'b1;

    // Vector table, continuous mode (R1 R3 R4 R5 R6 R7 R8)
    foreach (VECS[i]) begin
      pci_int_in_n = VECS[i].pin;
      run_cycle(VECS[i].pull, 1'b0, st, sl);
      chk("R1 start len", st, 4);
      chk("R3 stop len continuous", sl, 3);
      chk("R4/R5/R6 irq_n", {16'd0, irq_n}, {16'd0, VECS[i].irq});
      chk("R7 smi_req", {31'd0, smi_req}, {31'd0, VECS[i].smi});
      chk("R7 smi_sts", {31'd0, smi_sts}, {31'd0, VECS[i].sts});
      chk("R8 pci merge", {28'd0, pci_int_out_n}, {28'd0, VECS[i].pci});
    end

    // R5: levels held outside their sample clocks
    @(negedge clk);
    @(negedge clk);
    chk("R5 held irq_n", {16'd0, irq_n}, 32'h0000FF0F);
    chk("R5 held smi_req", {31'd0, smi_req}, 32'd1);

    // R7: clear the sticky status
    smi_sts_clr = 1'b1;
    @(negedge clk);
    smi_sts_clr = 1'b0;
    chk("R7 sts cleared", {31'd0, smi_sts}, 32'd0);

    // R3: short stop frame selects quiet mode
    short_stop = 1'b1;
    run_cycle(21'h0, 1'b0, st, sl);
    chk("R3 stop len quiet", sl, 2);
    chk("R7 sts stays clear", {31'd0, smi_sts}, 32'd0);
    chk("R6/R5 irq_n released", {16'd0, irq_n}, 32'h0000FFFF);

    // R2: host stays silent in quiet mode
    loud = 0;
    for (int w = 0; w < 12; w++) begin
      @(negedge clk);
      if (ser_line_oe) loud++;
    end
    chk("R2 quiet silent", loud, 0);

    // R2: device-initiated start, host finishes it; switch back to continuous
    short_stop = 1'b0;
    run_cycle(21'h00C00A, 1'b1, st, sl);
    chk("R2 host start part", st, 3);
    chk("R3 stop len back to continuous", sl, 3);
    chk("R4 irq_n quiet round", {16'd0, irq_n}, 32'h00003FF5);

    // R1: continuous mode resumes without a device start
    run_cycle(21'h000004, 1'b0, st, sl);
    chk("R1 start len resumed", st, 4);
    chk("R7 smi_req set", {31'd0, smi_req}, 32'd1);
    chk("R7 smi_sts set", {31'd0, smi_sts}, 32'd1);
    chk("R6 smi slot not an irq", {31'd0, irq_n[2]}, 32'd1);

    finish_run();
  end
endmodule